// File: doc/BRIEF.md
# Voltage and frequency operating-point sequencer

This block moves a processor core from one performance point to another. A write to the target port names one of six points. The block then brings the supply voltage and the core clock frequency to that point in an order that never leaves the core under-volted. The voltage code moves one unit per regulator handshake. The clock ratio changes only inside a short window in which the core clock and the PLL are held off. The core keeps running while the voltage steps.

A faster point is reached voltage-first: the code climbs to the new level, then the clock is switched. A slower point is reached frequency-first: the clock is switched, then the code descends. After each switch the block waits for the PLL to report lock before it re-enables the core clock. A timeout bounds this wait and leaves a sticky flag when it expires.

While the core clock is off, the block does not let interrupt, pin-event and snoop-request pulses fall away. It holds them in a four-entry queue and hands them to the core one per cycle, in arrival order, once the clock is back. A write that arrives during a transition is held and acted on when the transition ends.

Top module: `perf_point_seq`

## Requirements
- R1: After reset the block sits at point 5, with vid = 239, pll_ratio = 3, busy = 0, core_clk_en = 1, pll_en = 1, vreg_req = 0, pll_tmo = 0 and evt_ovf = 0, and all event outputs low.
- R2: Point index i (0 to 5) maps to vid = voltage in mV / 4 and pll_ratio = 8 - i. The six points are: 0 = 1484 mV (vid 371), 1 = 1420 mV (355), 2 = 1276 mV (319), 3 = 1164 mV (291), 4 = 1036 mV (259) and 5 = 956 mV (239). A finished transition leaves cur_idx, vid and pll_ratio at the target's values.
- R3: vid changes by exactly one code per step. It holds still while vreg_req is high and vreg_rdy is low. A move between points takes as many steps as the two codes differ.
- R4: On a move to a lower index (faster point), cur_idx changes only once vid has reached the target point's code.
- R5: On a move to a higher index (slower point), cur_idx changes first, while vid is still at the old point's code. At every cycle vid is at or above the code of the point in cur_idx.
- R6: core_clk_en stays high in every cycle where vreg_req is high.
- R7: cur_idx changes only while core_clk_en is low. pll_en drops for one cycle at the start of that window. Outside a frequency switch, core_clk_en is high.
- R8: After a switch, core_clk_en returns once pll_lock is seen. If pll_lock does not come, core_clk_en returns after LOCK_TO cycles of waiting (LOCK_TO + 1 gated cycles in all), and the sticky flag pll_tmo is set.
- R9: Event inputs sampled while core_clk_en is low are queued and do not appear on the outputs while the clock is off. After core_clk_en rises they appear one queued sample per cycle, in arrival order. The output vector is {snoop_o, pin_o, irq_o}.
- R10: With the clock running and the queue empty, an event input shows on the matching output one cycle later, for one cycle.
- R11: A sample that arrives while the queue holds 4 entries and nothing leaves is dropped, and evt_ovf is set and stays set. The first 4 entries are still delivered.
- R12: busy is high from the cycle after a valid write until the transition ends. A write during a transition is held; the latest such write wins and is carried out next.
- R13: A write with index 6 or 7 is ignored. A write of the current index causes no switch and no voltage step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_we | input | 1 | Target write strobe |
| tgt_idx | input | 3 | Target point index |
| busy | output | 1 | Transition in progress or pending |
| cur_idx | output | 3 | Point whose frequency is in effect |
| pll_ratio | output | 4 | PLL multiplier for cur_idx |
| vid | output | VID_W | Voltage code to the regulator |
| vreg_req | output | 1 | Regulator step request |
| vreg_rdy | input | 1 | Regulator settled at vid |
| pll_en | output | 1 | PLL run enable |
| pll_lock | input | 1 | PLL locked |
| core_clk_en | output | 1 | Core clock gate enable |
| pll_tmo | output | 1 | Sticky lock timeout flag |
| irq_i | input | 1 | Interrupt request in |
| pin_i | input | 1 | Pin event in |
| snoop_i | input | 1 | Snoop request in |
| irq_o | output | 1 | Interrupt to core |
| pin_o | output | 1 | Pin event to core |
| snoop_o | output | 1 | Snoop request to core |
| evt_ovf | output | 1 | Sticky event queue overflow |

## Verification
The assertions assume a well-behaved PLL. It drops pll_lock by the cycle after pll_en falls, and it never reports lock while disabled. They also assume the regulator raises vreg_rdy only while vreg_req is high. The bench builds both partners as models that keep to these rules. It drives events only while the block is idle or inside a gating window, never at the edge where the gate opens or closes. It also holds each write strobe for exactly one cycle.

// File: rtl/perf_point_seq.sv
module perf_point_seq #(
  parameter int VID_W     = 9,
  parameter int LOCK_TO   = 256,
  parameter int EVQ_DEPTH = 4,
  parameter int RST_IDX   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgt_we,
  input  logic [2:0]       tgt_idx,
  output logic             busy,
  output logic [2:0]       cur_idx,
  output logic [3:0]       pll_ratio,
  output logic [VID_W-1:0] vid,
  output logic             vreg_req,
  input  logic             vreg_rdy,
  output logic             pll_en,
  input  logic             pll_lock,
  output logic             core_clk_en,
  output logic             pll_tmo,
  input  logic             irq_i,
  input  logic             pin_i,
  input  logic             snoop_i,
  output logic             irq_o,
  output logic             pin_o,
  output logic             snoop_o,
  output logic             evt_ovf
);
  localparam int NPT       = 6;
  localparam int RATIO_TOP = 8;
  localparam int TMR_W     = $clog2(LOCK_TO) + 1;
  localparam int QA_W      = $clog2(EVQ_DEPTH);
  localparam int EV_W      = 3;

  typedef enum logic [2:0] {S_IDLE, S_VSET, S_VWAIT, S_GATE, S_LOCK} st_t;

  function automatic logic [VID_W-1:0] vid_of(input logic [2:0] i);
    case (i)
      3'd0:    vid_of = VID_W'(371);
      3'd1:    vid_of = VID_W'(355);
      3'd2:    vid_of = VID_W'(319);
      3'd3:    vid_of = VID_W'(291);
      3'd4:    vid_of = VID_W'(259);
      default: vid_of = VID_W'(239);
    endcase
  endfunction

  st_t              st;
  logic [2:0]       goal, pend_idx;
  logic             pend_v, raising;
  logic [TMR_W-1:0] tmr;
  logic [VID_W-1:0] goal_vid;
  logic             wr_ok;

  assign wr_ok       = tgt_we && (tgt_idx < 3'(NPT));
  assign goal_vid    = vid_of(goal);
  assign busy        = (st != S_IDLE) || pend_v;
  assign vreg_req    = (st == S_VWAIT);
  assign pll_en      = (st != S_GATE);
  assign core_clk_en = !((st == S_GATE) || (st == S_LOCK));
  assign pll_ratio   = 4'(RATIO_TOP) - {1'b0, cur_idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      goal     <= 3'(RST_IDX);
      pend_idx <= 3'(RST_IDX);
      pend_v   <= 1'b0;
      raising  <= 1'b0;
      cur_idx  <= 3'(RST_IDX);
      vid      <= vid_of(3'(RST_IDX));
      tmr      <= '0;
      pll_tmo  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (pend_v) begin
          pend_v <= 1'b0;
          goal   <= pend_idx;
          if (pend_idx < cur_idx) begin
            raising <= 1'b1;
            st      <= S_VSET;
          end else if (pend_idx > cur_idx) begin
            raising <= 1'b0;
            st      <= S_GATE;
          end
        end
        S_VSET: begin
          vid <= raising ? vid + 1'b1 : vid - 1'b1;
          st  <= S_VWAIT;
        end
        S_VWAIT: if (vreg_rdy) begin
          if (vid != goal_vid) st <= S_VSET;
          else                 st <= raising ? S_GATE : S_IDLE;
        end
        S_GATE: begin
          cur_idx <= goal;
          tmr     <= '0;
          st      <= S_LOCK;
        end
        S_LOCK: begin
          tmr <= tmr + 1'b1;
          if (pll_lock) begin
            st <= raising ? S_IDLE : S_VSET;
          end else if (tmr == TMR_W'(LOCK_TO - 1)) begin
            pll_tmo <= 1'b1;
            st      <= raising ? S_IDLE : S_VSET;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (wr_ok) begin
        pend_v   <= 1'b1;
        pend_idx <= tgt_idx;
      end
    end
  end

  logic [EV_W-1:0] evq [EVQ_DEPTH];
  logic [QA_W-1:0] rd_p, wr_p;
  logic [QA_W:0]   cnt;
  logic [EV_W-1:0] ev_in, ev_q;
  logic            gated, q_empty, q_full, pop, bypass, push_try, push;

  assign ev_in    = {snoop_i, pin_i, irq_i};
  assign gated    = !core_clk_en;
  assign q_empty  = (cnt == '0);
  assign q_full   = (cnt == (QA_W+1)'(EVQ_DEPTH));
  assign pop      = !gated && !q_empty;
  assign bypass   = !gated && q_empty;
  assign push_try = (|ev_in) && !bypass;
  assign push     = push_try && (!q_full || pop);
  assign {snoop_o, pin_o, irq_o} = ev_q;

  always_ff @(posedge clk) begin
    if (push) evq[wr_p] <= ev_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p    <= '0;
      wr_p    <= '0;
      cnt     <= '0;
      ev_q    <= '0;
      evt_ovf <= 1'b0;
    end else begin
      if (push) wr_p <= wr_p + 1'b1;
      if (pop)  rd_p <= rd_p + 1'b1;
      cnt <= cnt + (QA_W+1)'(push) - (QA_W+1)'(pop);
      if (pop)         ev_q <= evq[rd_p];
      else if (bypass) ev_q <= ev_in;
      else             ev_q <= '0;
      if (push_try && q_full && !pop) evt_ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/perf_point_seq_chk.sv
module perf_point_seq_chk #(
  parameter int VID_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [2:0]       cur_idx,
  input logic [VID_W-1:0] vid,
  input logic             vreg_req,
  input logic             vreg_rdy,
  input logic             pll_en,
  input logic             core_clk_en,
  input logic             pll_tmo,
  input logic             irq_o,
  input logic             pin_o,
  input logic             snoop_o,
  input logic             evt_ovf
);
  function automatic logic [VID_W-1:0] vmin(input logic [2:0] i);
    case (i)
      3'd0:    vmin = VID_W'(371);
      3'd1:    vmin = VID_W'(355);
      3'd2:    vmin = VID_W'(319);
      3'd3:    vmin = VID_W'(291);
      3'd4:    vmin = VID_W'(259);
      default: vmin = VID_W'(239);
    endcase
  endfunction

  AST_VID_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    vid != $past(vid) |-> (vid == $past(vid) + 1'b1) || (vid == $past(vid) - 1'b1)); // R3
  AST_VID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_req && !vreg_rdy |=> $stable(vid)); // R3
  AST_RAISE_VOLT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cur_idx < $past(cur_idx) |-> vid == vmin(cur_idx)); // R4
  AST_NO_UNDERVOLT: assert property (@(posedge clk) disable iff (!rst_n)
    vid >= vmin(cur_idx)); // R5
  AST_CLK_DURING_VSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_req |-> core_clk_en); // R6
  AST_FSW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cur_idx != $past(cur_idx) |-> !core_clk_en); // R7
  AST_PLL_OFF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> !core_clk_en); // R7
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pll_tmo) |-> pll_tmo); // R8
  AST_EV_QUIET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en && !$past(core_clk_en) |-> !(irq_o || pin_o || snoop_o)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_ovf) |-> evt_ovf); // R11
  AST_IDLE_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> core_clk_en && !vreg_req); // R12
endmodule

bind perf_point_seq perf_point_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cur_idx(cur_idx), .vid(vid),
  .vreg_req(vreg_req), .vreg_rdy(vreg_rdy), .pll_en(pll_en),
  .core_clk_en(core_clk_en), .pll_tmo(pll_tmo), .irq_o(irq_o),
  .pin_o(pin_o), .snoop_o(snoop_o), .evt_ovf(evt_ovf)
);

// File: tb/perf_point_seq_test.sv
module perf_point_seq_test;
  localparam int LOCK_TO = 32;
  localparam int LK_DLY  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tgt_we = 1'b0;
  logic [2:0] tgt_idx = '0;
  logic busy, vreg_req, pll_en, core_clk_en, pll_tmo, evt_ovf;
  logic irq_o, pin_o, snoop_o;
  logic irq_i = 1'b0, pin_i = 1'b0, snoop_i = 1'b0;
  logic vreg_rdy = 1'b0, pll_lock = 1'b0, hang = 1'b0;
  logic [2:0] cur_idx;
  logic [3:0] pll_ratio;
  logic [8:0] vid;

  int tests = 0, fails = 0, cyc = 0, lk_cnt = 0;
  int steps, step_bad, fsw_n, vid_at_fsw, fsw_clk, under_bad, req_gated_bad;
  int gated_cyc, pll_off_seen, out_gated_bad, log_n;
  logic [2:0] evlog [16];
  logic [8:0] pv;
  logic [2:0] pc;
  logic       pclk;

  perf_point_seq #(.LOCK_TO(LOCK_TO)) uut (
    .clk(clk), .rst_n(rst_n), .tgt_we(tgt_we), .tgt_idx(tgt_idx), .busy(busy),
    .cur_idx(cur_idx), .pll_ratio(pll_ratio), .vid(vid), .vreg_req(vreg_req),
    .vreg_rdy(vreg_rdy), .pll_en(pll_en), .pll_lock(pll_lock),
    .core_clk_en(core_clk_en), .pll_tmo(pll_tmo), .irq_i(irq_i), .pin_i(pin_i),
    .snoop_i(snoop_i), .irq_o(irq_o), .pin_o(pin_o), .snoop_o(snoop_o),
    .evt_ovf(evt_ovf));

  always #4 clk = ~clk;

  function automatic int vtab(input int i);
    case (i)
      0: return 371; 1: return 355; 2: return 319;
      3: return 291; 4: return 259; default: return 239;
    endcase
  endfunction

  always @(negedge clk) begin
    vreg_rdy <= vreg_req && !vreg_rdy;
    if (!pll_en) begin pll_lock <= 1'b0; lk_cnt <= 0; end
    else if (!hang && !pll_lock) begin
      if (lk_cnt == LK_DLY) pll_lock <= 1'b1; else lk_cnt <= lk_cnt + 1;
    end
  end

  task automatic clr();
    steps = 0; step_bad = 0; fsw_n = 0; vid_at_fsw = -1; fsw_clk = -1;
    under_bad = 0; req_gated_bad = 0; gated_cyc = 0; pll_off_seen = 0;
    out_gated_bad = 0; log_n = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (vid != pv) begin
      steps++;
      if (vid != pv + 9'd1 && vid != pv - 9'd1) step_bad++;
    end
    if (cur_idx != pc) begin fsw_n++; vid_at_fsw = int'(vid); fsw_clk = int'(core_clk_en); end
    if (int'(vid) < vtab(int'(cur_idx))) under_bad++;
    if (vreg_req && !core_clk_en) req_gated_bad++;
    if (!core_clk_en) gated_cyc++;
    if (!pll_en) pll_off_seen++;
    if (!core_clk_en && !pclk && (irq_o || pin_o || snoop_o)) out_gated_bad++;
    if ({snoop_o, pin_o, irq_o} != 3'b0 && log_n < 16) begin
      evlog[log_n] = {snoop_o, pin_o, irq_o}; log_n++;
    end
    pv = vid; pc = cur_idx; pclk = core_clk_en;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic wr(input logic [2:0] i);
    @(negedge clk); tgt_we = 1'b1; tgt_idx = i;
    @(negedge clk); tgt_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, "R12 transition completes", n, 5000);
  endtask

  task automatic wait_gate(input logic lvl);
    int n = 0;
    while (core_clk_en != lvl && n < 2000) begin @(negedge clk); n++; end
    chk(n < 2000, "R7 gate edge reached", n, 2000);
  endtask

  task automatic ev(input logic [2:0] v);
    @(negedge clk); {snoop_i, pin_i, irq_i} = v;
  endtask

  task automatic t_reset();
    chk(cur_idx == 3'd5 && vid == 9'd239, "R1 reset point", int'(vid), 239);
    chk(pll_ratio == 4'd3, "R2 reset ratio", int'(pll_ratio), 3);
    chk(!busy && core_clk_en && pll_en && !vreg_req, "R1 reset controls",
        int'({busy, core_clk_en, pll_en, vreg_req}), 6);
    chk(!pll_tmo && !evt_ovf && !irq_o && !pin_o && !snoop_o, "R1 reset flags",
        int'({pll_tmo, evt_ovf, irq_o, pin_o, snoop_o}), 0);
  endtask

  task automatic t_raise();
    clr(); wr(3'd0); wait_idle();
    chk(cur_idx == 3'd0 && vid == 9'd371 && pll_ratio == 4'd8, "R2 point 0",
        int'(vid), 371);
    chk(steps == 132 && step_bad == 0, "R3 single steps 239->371", steps, 132);
    chk(fsw_n == 1 && vid_at_fsw == 371, "R4 voltage reached before switch", vid_at_fsw, 371);
    chk(req_gated_bad == 0, "R6 clock runs during steps", req_gated_bad, 0);
    chk(fsw_clk == 0 && pll_off_seen == 1, "R7 switch under gate, pll off one cycle",
        pll_off_seen, 1);
    chk(!pll_tmo && gated_cyc < LOCK_TO, "R8 lock ends gate", gated_cyc, LK_DLY + 3);
  endtask

  task automatic t_lower();
    clr(); wr(3'd3); wait_idle();
    chk(cur_idx == 3'd3 && vid == 9'd291 && pll_ratio == 4'd5, "R2 point 3",
        int'(vid), 291);
    chk(vid_at_fsw == 371, "R5 frequency switched before voltage drop", vid_at_fsw, 371);
    chk(steps == 80 && under_bad == 0, "R5 no undervolt, 80 steps", under_bad, 0);
  endtask

  task automatic t_bypass();
    clr(); ev(3'b001); ev(3'b000);
    chk(irq_o && !pin_o && !snoop_o, "R10 pass-through next cycle", int'(irq_o), 1);
    @(negedge clk);
    chk(!irq_o, "R10 single pulse", int'(irq_o), 0);
  endtask

  task automatic t_gate_events();
    clr(); wr(3'd4); wait_gate(1'b0);
    ev(3'b001); ev(3'b110); ev(3'b010); ev(3'b000);
    wait_idle(); repeat (4) @(negedge clk);
    chk(out_gated_bad == 0, "R9 quiet while gated", out_gated_bad, 0);
    chk(log_n == 3, "R9 replay count", log_n, 3);
    chk(evlog[0] == 3'b001 && evlog[1] == 3'b110 && evlog[2] == 3'b010,
        "R9 replay order", int'({evlog[0], evlog[1], evlog[2]}), 'o162);
    chk(!evt_ovf && cur_idx == 3'd4 && vid == 9'd259, "R11 no overflow at 3", int'(evt_ovf), 0);
  endtask

  task automatic t_overflow();
    clr(); wr(3'd5); wait_gate(1'b0);
    ev(3'b001); ev(3'b010); ev(3'b100); ev(3'b011); ev(3'b110); ev(3'b000);
    wait_idle(); repeat (4) @(negedge clk);
    chk(evt_ovf, "R11 overflow flag", int'(evt_ovf), 1);
    chk(log_n == 4 && evlog[0] == 3'b001 && evlog[1] == 3'b010 &&
        evlog[2] == 3'b100 && evlog[3] == 3'b011, "R11 first four kept", log_n, 4);
  endtask

  task automatic t_busy();
    clr(); wr(3'd1);
    chk(busy, "R12 busy after write", int'(busy), 1);
    wr(3'd2); wr(3'd0); wait_idle();
    chk(cur_idx == 3'd0 && vid == 9'd371, "R12 latest write wins", int'(cur_idx), 0);
    chk(fsw_n == 2, "R12 held write run after first", fsw_n, 2);
  endtask

  task automatic t_ignore();
    clr(); wr(3'd7); repeat (3) @(negedge clk);
    chk(!busy && cur_idx == 3'd0 && vid == 9'd371 && fsw_n == 0,
        "R13 index 7 ignored", int'(cur_idx), 0);
    wr(3'd0); repeat (3) @(negedge clk);
    chk(!busy && fsw_n == 0 && steps == 0, "R13 same index no-op", fsw_n + steps, 0);
  endtask

  task automatic t_timeout();
    clr(); hang = 1'b1; wr(3'd2); wait_gate(1'b0); wait_gate(1'b1);
    chk(gated_cyc == LOCK_TO + 1, "R8 timeout window", gated_cyc, LOCK_TO + 1);
    chk(pll_tmo, "R8 timeout flag", int'(pll_tmo), 1);
    hang = 1'b0; wait_idle();
    chk(cur_idx == 3'd2 && vid == 9'd319, "R8 transition finishes", int'(vid), 319);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    pv = vid; pc = cur_idx; pclk = core_clk_en;
    repeat (2) @(negedge clk);
    t_reset();
    repeat (LK_DLY + 4) @(negedge clk);
    t_raise();
    t_lower();
    t_bypass();
    t_gate_events();
    t_overflow();
    t_busy();
    t_ignore();
    t_timeout();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule